// File: doc/BRIEF.md
# Register Rename Map Unit

This unit sits between decode and issue. It takes one decoded instruction per cycle and replaces its architectural register numbers with physical storage tags. Each source operand is looked up in a map table that holds the latest physical tag for every architectural register. Each destination receives a fresh tag drawn from a pool of unused physical locations, and the map entry is then pointed at that tag. Because of this, false write-after-read and write-after-write dependences disappear, while every true read-after-write dependence is carried by the tag.

With the default sizing there are 8 architectural and 10 physical registers. The free pool is a last-in first-out stack: the most recently pushed tag is handed out first. A separate return port pushes tags back into the pool once downstream logic no longer needs them. When the pool is empty and the incoming instruction needs a destination, the unit lowers `in_ready` until a tag comes back. The upstream stage must hold the instruction during that time. The renamed instruction appears on registered outputs one cycle after it is accepted.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, the pool holds tags 8 and 9 with 9 on top, and `out_valid` is 0.
- R2: Source tags are read from the map as it stands before the same instruction's destination update. An instruction that reads and writes the same register gets the old tag for that source.
- R3: A destination takes the tag on top of the pool. From reset, the first allocation returns 9 and the second returns 8.
- R4: After an allocation, later instructions that read that architectural register receive the newly allocated tag.
- R5: Two successive instructions that write registers receive different tags, provided the first tag has not been returned in between.
- R6: When the pool is empty and `in_dst_en` is 1, `in_ready` is 0. No output appears and the map does not change.
- R7: An instruction with `in_dst_en` = 0 is accepted even when the pool is empty. It consumes no tag and its `out_dst` is 0.
- R8: A returned tag (`rel_valid` = 1) is pushed in the same cycle and becomes the next tag allocated. This also holds while the unit is stalled.
- R9: When an allocation and a return fall in the same cycle, the allocation gets the previous top tag. The returned tag takes that slot, and the pool level stays the same.
- R10: `out_valid` is 1 in exactly the cycle after each accepted instruction (`in_valid` and `in_ready` both 1). It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction present |
| in_src1 | input | 3 | First source architectural register |
| in_src2 | input | 3 | Second source architectural register |
| in_dst | input | 3 | Destination architectural register |
| in_dst_en | input | 1 | Instruction writes a destination |
| in_ready | output | 1 | Unit can accept the instruction this cycle |
| rel_valid | input | 1 | Return a tag to the pool |
| rel_tag | input | 4 | Tag being returned |
| out_valid | output | 1 | Renamed instruction present |
| out_src1 | output | 4 | Physical tag of first source |
| out_src2 | output | 4 | Physical tag of second source |
| out_dst | output | 4 | Newly allocated destination tag (0 if none) |
| out_dst_en | output | 1 | Renamed instruction writes a destination |

## Verification
A tag return and a destination allocation can fall in the same cycle. They can also coincide while the unit is stalled on an empty pool, where the return alone must lift the stall. The stimulus table drives a return in the same cycle as a stalled destination instruction, and again in the same cycle as an accepted allocation. The result is judged by the tag that instruction receives and by the tag handed to the next writer, which must be the returned one. A bound property also checks that the pool level does not move when both happen together.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Pool level after a cycle that may pop one tag and may push one tag.
  function automatic int unsigned pool_level_next(int unsigned lvl, logic take, logic give);
    return lvl + (give ? 1 : 0) - (take ? 1 : 0);
  endfunction

  // Slot that a push writes: the vacated top when popping, else one above top.
  function automatic int unsigned push_slot(int unsigned lvl, logic take);
    return take ? lvl - 1 : lvl;
  endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int ARCH = 8,
  parameter int PHYS = 10,
  localparam int AW = $clog2(ARCH),
  localparam int PW = $clog2(PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  output logic [PW-1:0] tag_a,
  output logic [PW-1:0] tag_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [PW-1:0] wr_tag
);
  logic [PW-1:0] map_q [ARCH];

  // Reads see the table before this cycle's write.
  assign tag_a = map_q[rd_a];
  assign tag_b = map_q[rd_b];

  for (genvar g = 0; g < ARCH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[g] <= PW'(g);
      else if (wr_en && wr_addr == AW'(g))
        map_q[g] <= wr_tag;
    end
  end
endmodule

// File: rtl/rename_free_pool.sv
module rename_free_pool
  import rename_pkg::*;
#(
  parameter int ARCH = 8,
  parameter int PHYS = 10,
  localparam int PW = $clog2(PHYS),
  localparam int LW = $clog2(PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [PW-1:0] top_tag,
  output logic          empty,
  output logic [LW-1:0] level
);
  localparam int INIT_FREE = PHYS - ARCH;

  logic [PW-1:0] stack_q [PHYS];
  logic [LW-1:0] level_q;
  logic [PW-1:0] top_idx;
  logic [PW-1:0] wr_idx;
  logic          push_ok;

  assign empty   = (level_q == '0);
  assign level   = level_q;
  assign top_idx = PW'(level_q - LW'(1));
  assign top_tag = empty ? '0 : stack_q[top_idx];
  assign wr_idx  = PW'(push_slot(int'(level_q), pop));
  assign push_ok = push && (pop || level_q < LW'(PHYS));

  for (genvar g = 0; g < PHYS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        stack_q[g] <= (g < INIT_FREE) ? PW'(ARCH + g) : '0;
      else if (push_ok && wr_idx == PW'(g))
        stack_q[g] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      level_q <= LW'(INIT_FREE);
    else
      level_q <= LW'(pool_level_next(int'(level_q), pop, push_ok));
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int ARCH = 8,
  parameter int PHYS = 10,
  localparam int AW = $clog2(ARCH),
  localparam int PW = $clog2(PHYS),
  localparam int LW = $clog2(PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_src1,
  input  logic [AW-1:0] in_src2,
  input  logic [AW-1:0] in_dst,
  input  logic          in_dst_en,
  output logic          in_ready,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag,
  output logic          out_valid,
  output logic [PW-1:0] out_src1,
  output logic [PW-1:0] out_src2,
  output logic [PW-1:0] out_dst,
  output logic          out_dst_en
);
  // Named internal events, visible to the bound checker.
  logic          do_accept;
  logic          do_alloc;
  logic          pool_empty;
  logic [LW-1:0] pool_level;
  logic [PW-1:0] new_tag;
  logic [PW-1:0] src1_tag;
  logic [PW-1:0] src2_tag;

  assign in_ready  = !(in_dst_en && pool_empty);
  assign do_accept = in_valid && in_ready;
  assign do_alloc  = do_accept && in_dst_en;

  rename_map_table #(.ARCH(ARCH), .PHYS(PHYS)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a(in_src1), .rd_b(in_src2),
    .tag_a(src1_tag), .tag_b(src2_tag),
    .wr_en(do_alloc), .wr_addr(in_dst), .wr_tag(new_tag)
  );

  rename_free_pool #(.ARCH(ARCH), .PHYS(PHYS)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .pop(do_alloc), .push(rel_valid), .push_tag(rel_tag),
    .top_tag(new_tag), .empty(pool_empty), .level(pool_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_src1   <= '0;
      out_src2   <= '0;
      out_dst    <= '0;
      out_dst_en <= 1'b0;
    end else begin
      out_valid <= do_accept;
      if (do_accept) begin
        out_src1   <= src1_tag;
        out_src2   <= src2_tag;
        out_dst    <= in_dst_en ? new_tag : '0;
        out_dst_en <= in_dst_en;
      end
    end
  end
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int PHYS = 10,
  localparam int PW = $clog2(PHYS),
  localparam int LW = $clog2(PHYS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_dst_en,
  input logic          in_ready,
  input logic          rel_valid,
  input logic          out_valid,
  input logic          out_dst_en,
  input logic [PW-1:0] out_dst,
  input logic          do_accept,
  input logic          do_alloc,
  input logic          pool_empty,
  input logic [LW-1:0] pool_level
);
  assert_stall_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dst_en && pool_empty) |-> !in_ready);

  assert_out_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_accept |=> out_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !do_accept |=> !out_valid);

  assert_waw_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dst_en && $past(out_valid && out_dst_en)) |-> out_dst != $past(out_dst));

  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && rel_valid) |=> $stable(pool_level));

  assert_nodst_keeps_pool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_accept && !in_dst_en && !rel_valid) |=> $stable(pool_level));

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pool_level <= LW'(PHYS));
endmodule

bind rename_unit rename_unit_chk #(.PHYS(PHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_en(in_dst_en),
  .in_ready(in_ready), .rel_valid(rel_valid), .out_valid(out_valid),
  .out_dst_en(out_dst_en), .out_dst(out_dst), .do_accept(do_accept),
  .do_alloc(do_alloc), .pool_empty(pool_empty), .pool_level(pool_level)
);

// File: tb/rename_unit_test.sv
module rename_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic in_dst_en = 1'b0;
  logic in_ready;
  logic rel_valid = 1'b0;
  logic [3:0] rel_tag = '0;
  logic out_valid, out_dst_en;
  logic [3:0] out_src1, out_src2, out_dst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_unit uut (.*);

  typedef struct packed {
    logic [2:0] s1; logic [2:0] s2; logic [2:0] d; logic den;
    logic rv; logic [3:0] rt;
    logic rdy; logic [3:0] e1; logic [3:0] e2; logic [3:0] ed;
  } vec_t;

  // Expected tags worked out by hand from the requirements, starting at reset.
  localparam vec_t VEC [9] = '{
    '{3'd2, 3'd3, 3'd1, 1'b1, 1'b0, 4'd0, 1'b1, 4'd2, 4'd3, 4'd9}, // R3 first alloc 9
    '{3'd1, 3'd5, 3'd4, 1'b1, 1'b0, 4'd0, 1'b1, 4'd9, 4'd5, 4'd8}, // R4 RAW, R3 second 8
    '{3'd4, 3'd1, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd8, 4'd9, 4'd0}, // R7 empty pool, no dst
    '{3'd6, 3'd7, 3'd5, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0, 4'd0}, // R6 stall
    '{3'd6, 3'd7, 3'd5, 1'b1, 1'b1, 4'd4, 1'b0, 4'd0, 4'd0, 4'd0}, // R8 return while stalled
    '{3'd6, 3'd7, 3'd5, 1'b1, 1'b0, 4'd0, 1'b1, 4'd6, 4'd7, 4'd4}, // R8 returned tag used
    '{3'd5, 3'd4, 3'd0, 1'b0, 1'b1, 4'd5, 1'b1, 4'd4, 4'd8, 4'd0}, // R7 no dst + return
    '{3'd5, 3'd1, 3'd5, 1'b1, 1'b1, 4'd1, 1'b1, 4'd4, 4'd9, 4'd5}, // R2 same reg, R9 both
    '{3'd5, 3'd0, 3'd5, 1'b1, 1'b0, 4'd0, 1'b1, 4'd5, 4'd0, 4'd1}  // R5 distinct, R9 slot
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s1, input logic [2:0] s2, input logic [2:0] d,
                       input logic den, input logic rv, input logic [3:0] rt);
    in_valid = 1'b1; in_src1 = s1; in_src2 = s2; in_dst = d; in_dst_en = den;
    rel_valid = rv; rel_tag = rt;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_dst_en = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 out_valid after reset", 16'(out_valid), 16'd0);

    // Table walk: inputs at negedge, ready checked before the edge,
    // registered outputs checked at the following negedge.
    for (int i = 0; i < 9; i++) begin
      drive(VEC[i].s1, VEC[i].s2, VEC[i].d, VEC[i].den, VEC[i].rv, VEC[i].rt);
      #1;
      chk($sformatf("R6 in_ready vec%0d", i), 16'(in_ready), 16'(VEC[i].rdy));
      @(negedge clk);
      chk($sformatf("R10 out_valid vec%0d", i), 16'(out_valid), 16'(VEC[i].rdy));
      if (VEC[i].rdy) begin
        chk($sformatf("R2 src1 vec%0d", i), 16'(out_src1), 16'(VEC[i].e1));
        chk($sformatf("R2 src2 vec%0d", i), 16'(out_src2), 16'(VEC[i].e2));
        chk($sformatf("R3 dst vec%0d", i), 16'(out_dst), 16'(VEC[i].ed));
        chk($sformatf("R7 dst_en vec%0d", i), 16'(out_dst_en), 16'(VEC[i].den));
      end
    end

    // R10: an idle cycle gives no output.
    idle();
    @(negedge clk);
    chk("R10 idle out_valid", 16'(out_valid), 16'd0);

    // R6: map unchanged by the stalled F5 writes; F5 was last given tag 1.
    drive(3'd5, 3'd6, 3'd0, 1'b0, 1'b0, 4'd0);
    @(negedge clk);
    chk("R6 map after stall src1", 16'(out_src1), 16'd1);
    chk("R4 F6 untouched src2", 16'(out_src2), 16'd6);

    // R1: re-reset restores the identity map and the pool {8,9}.
    do_reset();
    chk("R1 out_valid on reset", 16'(out_valid), 16'd0);
    for (int a = 0; a < 8; a += 2) begin
      drive(3'(a), 3'(a + 1), 3'd0, 1'b0, 1'b0, 4'd0);
      @(negedge clk);
      chk($sformatf("R1 identity src1 a=%0d", a), 16'(out_src1), 16'(a));
      chk($sformatf("R1 identity src2 a=%0d", a + 1), 16'(out_src2), 16'(a + 1));
    end
    drive(3'd0, 3'd0, 3'd7, 1'b1, 1'b0, 4'd0);
    @(negedge clk);
    chk("R1 pool top after reset", 16'(out_dst), 16'd9);
    drive(3'd7, 3'd0, 3'd7, 1'b1, 1'b0, 4'd0);
    #1;
    chk("R1 second free tag ready", 16'(in_ready), 16'd1);
    @(negedge clk);
    chk("R2 src reads prior own map", 16'(out_src1), 16'd9);
    chk("R5 second write distinct", 16'(out_dst), 16'd8);
    drive(3'd7, 3'd0, 3'd7, 1'b1, 1'b0, 4'd0);
    #1;
    chk("R6 pool of two exhausted", 16'(in_ready), 16'd0);
    idle();
    @(negedge clk);
    chk("R6 no output while stalled", 16'(out_valid), 16'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule